// File: doc/BRIEF.md
# Interleaved CPU and Display Memory Bus Sequencer

This block lets a slow host CPU and a display fetch engine share one memory bus without double-speed memory. A fast clock running at six times the CPU rate divides every CPU cycle into six phases. In each cycle the block produces the CPU phase clock and steers the address multiplexer between the CPU address and a display address. It also issues single-cycle strobes that latch the memory address, capture the low and high display bytes, and capture the CPU read byte.

The CPU address is on the bus in phases 0 and 1, and the memory latches it in phase 1. From phase 2 onward a display address is issued and held. The bus returns the low byte of the previous display request by the end of phase 2 and the high byte by the end of phase 4. It returns the CPU byte in phase 5. So CPU memory has from the end of phase 1 to the end of phase 4 to answer. The display address pointer advances by one with every issue and can be loaded from outside. The assembled display word is flagged valid in phase 5.

Top module: `membus_interleaver`

## Requirements
- R1: While reset is asserted, and for the two fast-clock cycles after its release, the outputs show phase 0: `cpu_phi`=1, `mem_sel`=0, every strobe and `disp_valid` low, and `disp_word` and `cpu_rdata` zero.
- R2: Once reset is over, the phase is (edges counted from the third rising edge after release) modulo 6. It steps 0,1,2,3,4,5 and then wraps to 0.
- R3: `cpu_phi` is 1 in phases 0, 1 and 2 and 0 in phases 3, 4 and 5.
- R4: `mem_sel`=0 and `mem_addr` equals `cpu_addr` in phases 0 and 1. `mem_sel`=1 in phases 2 to 5, and `mem_addr` then holds one display issue address that does not change through those four phases.
- R5: `addr_latch_stb` is high only in phase 1.
- R6: `disp_lo_stb` is high only in phase 2, and the bus value present in phase 2 becomes bits [DW-1:0] of `disp_word`. `disp_hi_stb` is high only in phase 4, and the bus value present in phase 4 becomes bits [2*DW-1:DW].
- R7: `disp_valid` is high only in phase 5. At that point `disp_word` holds the high and low bytes captured in phases 4 and 2 of the same CPU cycle.
- R8: `cpu_data_stb` is high only in phase 5. From the next phase 0 on, `cpu_rdata` holds the bus value present in phase 5 until the next capture.
- R9: Each phase-2 issue uses the current display pointer, and the pointer then increments by one modulo 2^AW.
- R10: A `disp_load` high at a rising edge sets the pointer to `disp_addr_in`. A load wins over the increment on the edge that ends phase 1, and the loaded value is used at the next issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, six times the CPU rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | AW | Address requested by the CPU |
| disp_load | input | 1 | Load strobe for the display pointer |
| disp_addr_in | input | AW | New display pointer value |
| mem_data | input | DW | Shared memory data bus |
| cpu_phi | output | 1 | CPU phase clock |
| mem_sel | output | 1 | Multiplexer select, 1 = display address |
| mem_addr | output | AW | Multiplexed memory address |
| addr_latch_stb | output | 1 | External address latch strobe (phase 1) |
| disp_lo_stb | output | 1 | Display low-byte capture strobe (phase 2) |
| disp_hi_stb | output | 1 | Display high-byte capture strobe (phase 4) |
| cpu_data_stb | output | 1 | CPU read-data capture strobe (phase 5) |
| disp_valid | output | 1 | Display word valid (phase 5) |
| disp_word | output | 2*DW | Captured display high and low bytes |
| cpu_rdata | output | DW | Captured CPU read byte |

## Verification
A phase counter that skips or repeats a state shows within one fast-clock cycle: the strobe pattern and `cpu_phi` fall out of their fixed six-step order. A display pointer that is wrong, or a load that loses to the increment, shows in the next phase-2 value of `mem_addr`. A capture strobe at the wrong moment puts the wrong bus value into `disp_word` or `cpu_rdata`, and that is visible by the following phase 5 or phase 0. The bench runs every phase many times with a different bus value in every cycle. It places loads on the increment edge and on other edges, and it drives the pointer through its wrap.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  localparam int unsigned NUM_PHASES = 6;
  localparam int unsigned PHW        = $clog2(NUM_PHASES);

  typedef logic [PHW-1:0] phase_t;

  localparam phase_t PH_FIRST     = phase_t'(0);
  localparam phase_t PH_LAST      = phase_t'(NUM_PHASES - 1);
  localparam phase_t PH_ALATCH    = phase_t'(1);
  localparam phase_t PH_DISP_LO   = phase_t'(2);
  localparam phase_t PH_DISP_HI   = phase_t'(4);
  localparam phase_t PH_CPU_DATA  = phase_t'(5);
  localparam phase_t PH_PHI_LAST  = phase_t'(2);
  localparam phase_t PH_DISP_ADDR = phase_t'(2);

  typedef struct packed {
    logic phi;
    logic sel;
    logic alatch;
    logic lo;
    logic hi;
    logic cpu;
    logic dvalid;
  } ctl_t;

  function automatic ctl_t phase_decode(phase_t p);
    ctl_t c;
    c.phi    = (p <= PH_PHI_LAST);
    c.sel    = (p >= PH_DISP_ADDR);
    c.alatch = (p == PH_ALATCH);
    c.lo     = (p == PH_DISP_LO);
    c.hi     = (p == PH_DISP_HI);
    c.cpu    = (p == PH_CPU_DATA);
    c.dvalid = (p == PH_CPU_DATA);
    return c;
  endfunction
endpackage

// File: rtl/mbi_rst_sync.sv
module mbi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mbi_phase_gen.sv
module mbi_phase_gen
  import mbi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t ph_nxt
);
  phase_t ph_q;
  phase_t ph_d;

  always_comb begin
    if (ph_q == PH_LAST) ph_d = PH_FIRST;
    else                 ph_d = ph_q + phase_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_FIRST;
    else        ph_q <= ph_d;
  end

  assign ph_nxt = ph_d;
endmodule

// File: rtl/mbi_ctl_reg.sv
module mbi_ctl_reg
  import mbi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv_en,
  input  phase_t ph_nxt,
  output ctl_t   ctl_q
);
  localparam ctl_t CTL_RESET = phase_decode(PH_FIRST);

  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (adv_en) ctl_d = phase_decode(ph_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/mbi_disp_addr.sv
module mbi_disp_addr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_en,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] issue_addr
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] iss_q, iss_d;

  always_comb begin
    ptr_d = ptr_q;
    iss_d = iss_q;
    if (issue_en) begin
      iss_d = ptr_q;
      ptr_d = ptr_q + AW'(1);
    end
    if (load_en) ptr_d = load_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      iss_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      iss_q <= iss_d;
    end
  end

  assign issue_addr = iss_q;
endmodule

// File: rtl/mbi_capture.sv
module mbi_capture #(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_en,
  input  logic            hi_en,
  input  logic            cpu_en,
  input  logic [DW-1:0]   bus,
  output logic [2*DW-1:0] word,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] lo_q, lo_d;
  logic [DW-1:0] hi_q, hi_d;
  logic [DW-1:0] rd_q, rd_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    rd_d = rd_q;
    if (lo_en)  lo_d = bus;
    if (hi_en)  hi_d = bus;
    if (cpu_en) rd_d = bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      rd_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      rd_q <= rd_d;
    end
  end

  assign word  = {hi_q, lo_q};
  assign rdata = rd_q;
endmodule

// File: rtl/membus_interleaver.sv
module membus_interleaver
  import mbi_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cpu_addr,
  input  logic            disp_load,
  input  logic [AW-1:0]   disp_addr_in,
  input  logic [DW-1:0]   mem_data,
  output logic            cpu_phi,
  output logic            mem_sel,
  output logic [AW-1:0]   mem_addr,
  output logic            addr_latch_stb,
  output logic            disp_lo_stb,
  output logic            disp_hi_stb,
  output logic            cpu_data_stb,
  output logic            disp_valid,
  output logic [2*DW-1:0] disp_word,
  output logic [DW-1:0]   cpu_rdata
);
  logic          rst_core_n;
  phase_t        ph_nxt;
  ctl_t          ctl;
  logic [AW-1:0] disp_issue;

  mbi_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mbi_phase_gen u_phase (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .ph_nxt (ph_nxt)
  );

  mbi_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .adv_en (1'b1),
    .ph_nxt (ph_nxt),
    .ctl_q  (ctl)
  );

  mbi_disp_addr #(.AW(AW)) u_daddr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .issue_en   (ctl.alatch),
    .load_en    (disp_load),
    .load_addr  (disp_addr_in),
    .issue_addr (disp_issue)
  );

  mbi_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .lo_en  (ctl.lo),
    .hi_en  (ctl.hi),
    .cpu_en (ctl.cpu),
    .bus    (mem_data),
    .word   (disp_word),
    .rdata  (cpu_rdata)
  );

  assign mem_addr       = ctl.sel ? disp_issue : cpu_addr;
  assign cpu_phi        = ctl.phi;
  assign mem_sel        = ctl.sel;
  assign addr_latch_stb = ctl.alatch;
  assign disp_lo_stb    = ctl.lo;
  assign disp_hi_stb    = ctl.hi;
  assign cpu_data_stb   = ctl.cpu;
  assign disp_valid     = ctl.dvalid;
endmodule

// File: rtl/mbi_checker.sv
module mbi_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_phi,
  input logic            mem_sel,
  input logic [AW-1:0]   mem_addr,
  input logic            addr_latch_stb,
  input logic            disp_lo_stb,
  input logic            disp_hi_stb,
  input logic            cpu_data_stb,
  input logic            disp_valid,
  input logic [DW-1:0]   mem_data,
  input logic [2*DW-1:0] disp_word,
  input logic [DW-1:0]   cpu_rdata
);
  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_data_stb |=> (cpu_phi && !mem_sel && !cpu_data_stb));

  p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_latch_stb, disp_lo_stb, disp_hi_stb, cpu_data_stb}));

  p_lo_after_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch_stb |=> (disp_lo_stb && mem_sel));

  p_hi_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_hi_stb |-> $past(disp_lo_stb, 2));

  p_valid_after_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(disp_hi_stb));

  p_phi_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_phi) |-> $past(disp_lo_stb));

  p_disp_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel && !disp_lo_stb) |-> $stable(mem_addr));

  p_lo_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_lo_stb |=> (disp_word[DW-1:0] == $past(mem_data)));

  p_rdata_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_data_stb |=> (cpu_rdata == $past(mem_data)));
endmodule

bind membus_interleaver mbi_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_phi        (cpu_phi),
  .mem_sel        (mem_sel),
  .mem_addr       (mem_addr),
  .addr_latch_stb (addr_latch_stb),
  .disp_lo_stb    (disp_lo_stb),
  .disp_hi_stb    (disp_hi_stb),
  .cpu_data_stb   (cpu_data_stb),
  .disp_valid     (disp_valid),
  .mem_data       (mem_data),
  .disp_word      (disp_word),
  .cpu_rdata      (cpu_rdata)
);

// File: tb/membus_interleaver_tb.sv
`timescale 1ns/1ps
module membus_interleaver_tb;
  localparam int AW = 8;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   cpu_addr;
  logic            disp_load;
  logic [AW-1:0]   disp_addr_in;
  logic [DW-1:0]   mem_data;
  logic            cpu_phi, mem_sel, addr_latch_stb, disp_lo_stb, disp_hi_stb;
  logic            cpu_data_stb, disp_valid;
  logic [AW-1:0]   mem_addr;
  logic [2*DW-1:0] disp_word;
  logic [DW-1:0]   cpu_rdata;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  membus_interleaver #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .disp_load(disp_load),
    .disp_addr_in(disp_addr_in), .mem_data(mem_data), .cpu_phi(cpu_phi),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .addr_latch_stb(addr_latch_stb),
    .disp_lo_stb(disp_lo_stb), .disp_hi_stb(disp_hi_stb),
    .cpu_data_stb(cpu_data_stb), .disp_valid(disp_valid),
    .disp_word(disp_word), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk_phase0(input string tag);
    chk({tag, " R1 phi"}, cpu_phi, 1);
    chk({tag, " R1 sel"}, mem_sel, 0);
    chk({tag, " R1 strobes"}, {addr_latch_stb, disp_lo_stb, disp_hi_stb, cpu_data_stb, disp_valid}, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int ph;
    logic [DW-1:0] lo_m, hi_m, rd_m;
    logic [AW-1:0] ptr_m, iss_m;
    rst_n = 1'b0; cpu_addr = '0; disp_load = 1'b0; disp_addr_in = '0; mem_data = '0;
    repeat (3) @(negedge clk);
    chk_phase0("reset");
    chk("R1 word", disp_word, 0);
    chk("R1 rdata", cpu_rdata, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); @(negedge clk);
      chk_phase0("sync");
    end
    ph = 0; lo_m = '0; hi_m = '0; rd_m = '0; ptr_m = '0; iss_m = '0;
    for (int n = 0; n < 360; n++) begin
      cpu_addr     = AW'(n * 13 + 7);
      mem_data     = DW'(n * 37 + 5);
      disp_load    = (n == 3) || (n == 37) || (n == 100);
      disp_addr_in = (n == 3) ? AW'(8'h40) : (n == 37) ? AW'(8'hFE) : AW'(8'h10);
      if (ph == 2) lo_m = mem_data;
      if (ph == 4) hi_m = mem_data;
      if (ph == 5) rd_m = mem_data;
      if (ph == 1) begin
        iss_m = ptr_m;
        ptr_m = disp_load ? disp_addr_in : ptr_m + AW'(1);
      end else if (disp_load) begin
        ptr_m = disp_addr_in;
      end
      ph = (ph == 5) ? 0 : ph + 1;
      @(posedge clk); @(negedge clk);
      disp_load = 1'b0;
      chk("R2 R3 cpu_phi", cpu_phi, (ph < 3));
      chk("R4 mem_sel", mem_sel, (ph >= 2));
      if (ph < 2) chk("R4 cpu address", mem_addr, cpu_addr);
      else        chk("R4 R9 R10 display address", mem_addr, iss_m);
      chk("R5 addr_latch_stb", addr_latch_stb, (ph == 1));
      chk("R6 disp_lo_stb", disp_lo_stb, (ph == 2));
      chk("R6 disp_hi_stb", disp_hi_stb, (ph == 4));
      chk("R8 cpu_data_stb", cpu_data_stb, (ph == 5));
      chk("R7 disp_valid", disp_valid, (ph == 5));
      if (ph == 5) chk("R6 R7 disp_word", disp_word, {hi_m, lo_m});
      chk("R8 cpu_rdata", cpu_rdata, rd_m);
    end
    // reset in the middle of a cycle returns to phase 0 at once
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    chk_phase0("midrun");
    chk("R1 midrun word", disp_word, 0);
    chk("R1 midrun rdata", cpu_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_phase0("midrun sync");
    summary();
  end
endmodule